// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns the decoded control bits of a single-register memory transfer into the values a memory pipeline stage needs. It covers two instruction classes. In the word/unsigned-byte class the offset is a 12-bit immediate or a register. In the halfword/signed class the offset is a register or an 8-bit immediate delivered as two 4-bit fields. For each request it forms the effective address and the base-register update, and decides whether that update is written. It also produces the access size, a byte-enable mask and store data replicated into every lane.

Requests are captured on a clock edge and presented one cycle later. The load-data path is combinational. It takes the raw read word returned in the output cycle, picks the addressed byte or halfword lane from the registered low address bits, and sign- or zero-extends it to 32 bits. The next request can therefore be accepted in the same cycle that the previous load's data is being extended.

Top module: `ls_agu`

## Requirements
- R1: With pre_i=0 (post-index), addr_o equals the base and the base update base±offset is always written (wb_en_o=1), whatever wb_i is.
- R2: With pre_i=1 (pre-index), addr_o equals base±offset. wb_en_o is 1 only when wb_i=1, and wb_val_o then equals addr_o.
- R3: up_i=1 adds the offset to the base and up_i=0 subtracts it, modulo 2^32.
- R4: Word/byte class (cls_i=0): the offset is roff_i when roff_sel_i=1, otherwise imm12_i zero-extended. bi_i=1 selects a byte access (size_o=00), otherwise a word (size_o=10). load_i=1 selects a load.
- R5: Halfword class (cls_i=1): the offset is {imm_hi_i,imm_lo_i} when bi_i=1, otherwise roff_i. kind_i encodes 01 unsigned halfword, 10 signed byte and 11 signed halfword. size_o is 00 for the signed byte and 01 for both halfword kinds.
- R6: For a byte access be_o has the single bit addr_o[1:0] set, and wdata_o carries wdata_i[7:0] in all four lanes.
- R7: For a halfword access be_o is 4'b0011 when addr_o[1]=0 and 4'b1100 when addr_o[1]=1, and wdata_o carries wdata_i[15:0] in both halves. For a word access be_o is 4'b1111 and wdata_o equals wdata_i.
- R8: ldata_o takes the byte at lane addr_o[1:0] or the halfword at lane addr_o[1] of rdata_i. Signed kinds sign-extend it to 32 bits and the others zero-extend it. A word returns rdata_i unchanged. ldata_o follows rdata_i within the same cycle.
- R9: A halfword-class request with kind_i=00, or a store with kind_i 10 or 11, is illegal. It sets err_o=1 and forces be_o=0 and wb_en_o=0, while addr_o is still computed.
- R10: Outputs appear in the cycle after the edge that samples req_i=1, with vld_o=1. After a cycle without a request vld_o, be_o and wb_en_o are 0 and addr_o holds its value. Reset clears vld_o, be_o, wb_en_o and err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| cls_i | input | 1 | 0 word/byte class, 1 halfword/signed class |
| pre_i | input | 1 | 1 pre-index, 0 post-index |
| up_i | input | 1 | 1 add offset, 0 subtract |
| bi_i | input | 1 | Byte select (class 0) or split-immediate select (class 1) |
| wb_i | input | 1 | Writeback request for pre-index |
| load_i | input | 1 | 1 load, 0 store |
| roff_sel_i | input | 1 | Class 0: 1 register offset, 0 immediate |
| kind_i | input | 2 | Class 1 transfer kind |
| base_i | input | 32 | Base register value |
| roff_i | input | 32 | Register offset |
| imm12_i | input | 12 | Class 0 immediate |
| imm_hi_i | input | 4 | Class 1 immediate high nibble |
| imm_lo_i | input | 4 | Class 1 immediate low nibble |
| wdata_i | input | 32 | Store data |
| rdata_i | input | 32 | Raw memory read word |
| vld_o | output | 1 | Outputs valid |
| addr_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Base update enable |
| wb_val_o | output | 32 | Base update value |
| size_o | output | 2 | 00 byte, 01 halfword, 10 word |
| load_o | output | 1 | Access is a load |
| err_o | output | 1 | Illegal encoding |
| be_o | output | 4 | Byte enables |
| wdata_o | output | 32 | Lane-replicated store data |
| ldata_o | output | 32 | Aligned, extended load data |

## Verification
The registered address stage for a new request and the combinational extension of the previous load's data are both active in the same output cycle. The bench holds rdata_i across a capture edge and then changes it with no new request. It then checks that ldata_o tracks the new word through the lane and sign choice already latched, while addr_o and the other registered outputs stay unchanged. Every table vector also checks the address and writeback results together with the extended load data in one cycle, with lanes at each low-address position.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } size_e;

  typedef enum logic [1:0] {
    HK_NONE  = 2'b00,
    HK_UHALF = 2'b01,
    HK_SBYTE = 2'b10,
    HK_SHALF = 2'b11
  } hkind_e;
endpackage

// File: rtl/ls_agu_decode.sv
module ls_agu_decode
  import ls_agu_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 12,
  parameter int unsigned NIB_W = 4
) (
  input  logic             cls_i,
  input  logic             pre_i,
  input  logic             up_i,
  input  logic             bi_i,
  input  logic             wb_i,
  input  logic             load_i,
  input  logic             roff_sel_i,
  input  logic [1:0]       kind_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  roff_i,
  input  logic [IMM_W-1:0] imm12_i,
  input  logic [NIB_W-1:0] imm_hi_i,
  input  logic [NIB_W-1:0] imm_lo_i,
  output logic [XLEN-1:0]  addr_o,
  output logic [XLEN-1:0]  wbv_o,
  output logic             wb_en_o,
  output size_e            size_o,
  output logic             sgn_o,
  output logic             err_o
);
  logic [XLEN-1:0] off, disp, sum;

  always_comb begin
    if (cls_i) off = bi_i ? XLEN'({imm_hi_i, imm_lo_i}) : roff_i;
    else       off = roff_sel_i ? roff_i : XLEN'(imm12_i);
  end

  // sign applied to offset, then a single unconditional add
  assign disp   = up_i ? off : (~off + XLEN'(1));
  assign sum    = base_i + disp;
  assign addr_o = pre_i ? sum : base_i;
  assign wbv_o  = sum;

  assign err_o   = cls_i && ((kind_i == HK_NONE) || (!load_i && kind_i[1]));
  assign wb_en_o = !err_o && (!pre_i || wb_i);
  assign sgn_o   = cls_i && kind_i[1];

  always_comb begin
    if (cls_i) size_o = (kind_i == HK_SBYTE) ? SZ_BYTE : SZ_HALF;
    else       size_o = bi_i ? SZ_BYTE : SZ_WORD;
  end
endmodule

// File: rtl/ls_agu_lanes.sv
module ls_agu_lanes
  import ls_agu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned NB  = XLEN / 8,
  localparam int unsigned LB  = $clog2(NB)
) (
  input  logic            en_i,
  input  size_e           size_i,
  input  logic [LB-1:0]   addr_lo_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [NB-1:0]   be_o,
  output logic [XLEN-1:0] wdata_o
);
  logic [NB-1:0] be_raw;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam int unsigned LANE = i;
    assign be_raw[i] = (size_i == SZ_BYTE) ? (addr_lo_i == LANE[LB-1:0]) :
                       (size_i == SZ_HALF) ? (addr_lo_i[LB-1:1] == LANE[LB-1:1]) :
                                             1'b1;
    assign wdata_o[8*i +: 8] = (size_i == SZ_BYTE) ? wdata_i[7:0] :
                               (size_i == SZ_HALF) ? wdata_i[8*(i%2) +: 8] :
                                                     wdata_i[8*i +: 8];
  end

  assign be_o = en_i ? be_raw : '0;
endmodule

// File: rtl/ls_agu_extend.sv
module ls_agu_extend
  import ls_agu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned NB  = XLEN / 8,
  localparam int unsigned LB  = $clog2(NB)
) (
  input  size_e           size_i,
  input  logic            sgn_i,
  input  logic [LB-1:0]   addr_lo_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic [XLEN-1:0] ldata_o
);
  logic [XLEN-1:0] b_sh, h_sh;

  assign b_sh = rdata_i >> {addr_lo_i, 3'b000};
  assign h_sh = rdata_i >> {addr_lo_i[LB-1:1], 4'b0000};

  always_comb begin
    case (size_i)
      SZ_BYTE: ldata_o = sgn_i ? {{(XLEN-8){b_sh[7]}}, b_sh[7:0]}
                               : {{(XLEN-8){1'b0}}, b_sh[7:0]};
      SZ_HALF: ldata_o = sgn_i ? {{(XLEN-16){h_sh[15]}}, h_sh[15:0]}
                               : {{(XLEN-16){1'b0}}, h_sh[15:0]};
      default: ldata_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/ls_agu.sv
module ls_agu
  import ls_agu_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 12,
  parameter int unsigned NIB_W = 4,
  localparam int unsigned NB   = XLEN / 8,
  localparam int unsigned LB   = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             cls_i,
  input  logic             pre_i,
  input  logic             up_i,
  input  logic             bi_i,
  input  logic             wb_i,
  input  logic             load_i,
  input  logic             roff_sel_i,
  input  logic [1:0]       kind_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  roff_i,
  input  logic [IMM_W-1:0] imm12_i,
  input  logic [NIB_W-1:0] imm_hi_i,
  input  logic [NIB_W-1:0] imm_lo_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [XLEN-1:0]  rdata_i,
  output logic             vld_o,
  output logic [XLEN-1:0]  addr_o,
  output logic             wb_en_o,
  output logic [XLEN-1:0]  wb_val_o,
  output logic [1:0]       size_o,
  output logic             load_o,
  output logic             err_o,
  output logic [NB-1:0]    be_o,
  output logic [XLEN-1:0]  wdata_o,
  output logic [XLEN-1:0]  ldata_o
);
  logic [XLEN-1:0] d_addr, d_wbv;
  logic            d_wb_en, d_sgn, d_err;
  size_e           d_size;

  logic            vld_q, wb_en_q, sgn_q, err_q, ld_q;
  logic [XLEN-1:0] addr_q, wbv_q, wdata_q;
  size_e           size_q;

  ls_agu_decode #(.XLEN(XLEN), .IMM_W(IMM_W), .NIB_W(NIB_W)) u_dec (
    .cls_i, .pre_i, .up_i, .bi_i, .wb_i, .load_i, .roff_sel_i, .kind_i,
    .base_i, .roff_i, .imm12_i, .imm_hi_i, .imm_lo_i,
    .addr_o(d_addr), .wbv_o(d_wbv), .wb_en_o(d_wb_en),
    .size_o(d_size), .sgn_o(d_sgn), .err_o(d_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      wb_en_q <= 1'b0;
      sgn_q   <= 1'b0;
      err_q   <= 1'b0;
      ld_q    <= 1'b0;
      addr_q  <= '0;
      wbv_q   <= '0;
      wdata_q <= '0;
      size_q  <= SZ_WORD;
    end else begin
      vld_q <= req_i;
      if (req_i) begin
        wb_en_q <= d_wb_en;
        sgn_q   <= d_sgn;
        err_q   <= d_err;
        ld_q    <= load_i;
        addr_q  <= d_addr;
        wbv_q   <= d_wbv;
        wdata_q <= wdata_i;
        size_q  <= d_size;
      end
    end
  end

  ls_agu_lanes #(.XLEN(XLEN)) u_lanes (
    .en_i     (vld_q && !err_q),
    .size_i   (size_q),
    .addr_lo_i(addr_q[LB-1:0]),
    .wdata_i  (wdata_q),
    .be_o     (be_o),
    .wdata_o  (wdata_o)
  );

  ls_agu_extend #(.XLEN(XLEN)) u_ext (
    .size_i   (size_q),
    .sgn_i    (sgn_q),
    .addr_lo_i(addr_q[LB-1:0]),
    .rdata_i  (rdata_i),
    .ldata_o  (ldata_o)
  );

  assign vld_o    = vld_q;
  assign addr_o   = addr_q;
  assign wb_en_o  = vld_q && wb_en_q;
  assign wb_val_o = wbv_q;
  assign size_o   = size_q;
  assign load_o   = ld_q;
  assign err_o    = vld_q && err_q;

  assert_post_wb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !cls_i && !pre_i |=> wb_en_o && (addr_o == $past(base_i)));

  assert_pre_nowb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && pre_i && !wb_i |=> !wb_en_o);

  assert_byte_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !err_o && (size_o == SZ_BYTE) |-> $countones(be_o) == 1);

  assert_half_zext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && load_o && !err_o && (size_o == SZ_HALF) && !sgn_q |-> ldata_o[XLEN-1:16] == '0);

  assert_illegal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && cls_i && !load_i && kind_i[1] |=> err_o && (be_o == '0) && !wb_en_o);

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o && (be_o == '0) && !wb_en_o);
endmodule

// File: tb/ls_agu_test.sv
module ls_agu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req, cls, pre, up, bi, wb, ld, rsel;
  logic [1:0]  kind;
  logic [31:0] base, roff, wdat, rdat;
  logic [11:0] imm12;
  logic [3:0]  ihi, ilo;
  logic        vld, wb_en, ld_o, err;
  logic [31:0] addr, wbv, wdo, ldo;
  logic [1:0]  size;
  logic [3:0]  be;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ls_agu uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cls_i(cls), .pre_i(pre),
    .up_i(up), .bi_i(bi), .wb_i(wb), .load_i(ld), .roff_sel_i(rsel),
    .kind_i(kind), .base_i(base), .roff_i(roff), .imm12_i(imm12),
    .imm_hi_i(ihi), .imm_lo_i(ilo), .wdata_i(wdat), .rdata_i(rdat),
    .vld_o(vld), .addr_o(addr), .wb_en_o(wb_en), .wb_val_o(wbv),
    .size_o(size), .load_o(ld_o), .err_o(err), .be_o(be),
    .wdata_o(wdo), .ldata_o(ldo)
  );

  typedef struct packed {
    logic        cls, pre, up, bi, wb, ld, rsel;
    logic [1:0]  kind;
    logic [31:0] base, roff;
    logic [11:0] imm;
    logic [3:0]  hi, lo;
    logic [31:0] wd, rd, e_addr;
    logic [3:0]  e_be;
    logic        e_err;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,2'b00, 32'h1000, 32'h0, 12'h010, 4'h0,4'h0, 32'h0, 32'hCAFEF00D, 32'h1010, 4'hF, 1'b0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b00, 32'h2003, 32'h20, 12'h000, 4'h0,4'h0, 32'h000000AB, 32'h0, 32'h2003, 4'h8, 1'b0},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,2'b00, 32'h10000, 32'h0, 12'hFFF, 4'h0,4'h0, 32'h0, 32'h11228833, 32'hF001, 4'h2, 1'b0},
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,2'b11, 32'h3000, 32'h0, 12'h000, 4'h1,4'h2, 32'h0, 32'h80017FFF, 32'h3012, 4'hC, 1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01, 32'h4000, 32'h4, 12'h000, 4'h0,4'h0, 32'h1234ABCD, 32'h0, 32'h4000, 4'h3, 1'b0},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,2'b10, 32'h5000, 32'h0, 12'h000, 4'h0,4'h3, 32'h0, 32'h80000000, 32'h5003, 4'h8, 1'b0},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,2'b11, 32'h100, 32'h0, 12'h000, 4'h0,4'h4, 32'h0, 32'h0, 32'h104, 4'h0, 1'b1},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,2'b00, 32'h200, 32'h0, 12'h000, 4'h0,4'h0, 32'h0, 32'h0, 32'h200, 4'h0, 1'b1},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,2'b00, 32'h8, 32'hFFFFFFFC, 12'h000, 4'h0,4'h0, 32'h0, 32'h12345678, 32'h4, 4'hF, 1'b0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,2'b01, 32'h6004, 32'h0, 12'h000, 4'h0,4'h2, 32'h0, 32'hF00D1234, 32'h6002, 4'hC, 1'b0},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00, 32'h7000, 32'h0, 12'h004, 4'h0,4'h0, 32'hDEADBEEF, 32'h0, 32'h7004, 4'hF, 1'b0}
  };

  typedef struct packed {
    logic [31:0] wbv, wdo, ldo;
    logic        wb_en;
    logic [1:0]  size;
  } exp_t;

  function automatic exp_t model(vec_t v);
    exp_t e;
    logic [31:0] off, s, pick;
    logic        bad, signed_k;
    logic [1:0]  lo2;
    if (v.cls == 1'b0) off = v.rsel ? v.roff : {20'h0, v.imm};
    else               off = v.bi ? {24'h0, v.hi, v.lo} : v.roff;
    s = v.up ? (v.base + off) : (v.base - off);
    e.wbv = s;
    lo2 = v.pre ? s[1:0] : v.base[1:0];
    bad = v.cls && (v.kind == 2'b00 || (!v.ld && v.kind[1]));
    e.wb_en = !bad && (v.pre ? v.wb : 1'b1);
    signed_k = v.cls && v.kind[1];
    if (v.cls == 1'b0) e.size = v.bi ? 2'b00 : 2'b10;
    else               e.size = (v.kind == 2'b10) ? 2'b00 : 2'b01;
    case (e.size)
      2'b00: begin
        e.wdo = {4{v.wd[7:0]}};
        pick  = (v.rd >> (8 * lo2)) & 32'hFF;
        e.ldo = (signed_k && pick[7]) ? (pick | 32'hFFFFFF00) : pick;
      end
      2'b01: begin
        e.wdo = {2{v.wd[15:0]}};
        pick  = lo2[1] ? {16'h0, v.rd[31:16]} : {16'h0, v.rd[15:0]};
        e.ldo = (signed_k && pick[15]) ? (pick | 32'hFFFF0000) : pick;
      end
      default: begin
        e.wdo = v.wd;
        e.ldo = v.rd;
      end
    endcase
    return e;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    req = 1'b1; cls = v.cls; pre = v.pre; up = v.up; bi = v.bi; wb = v.wb;
    ld = v.ld; rsel = v.rsel; kind = v.kind; base = v.base; roff = v.roff;
    imm12 = v.imm; ihi = v.hi; ilo = v.lo; wdat = v.wd; rdat = v.rd;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual %h expected %h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    exp_t e;
    req = 0; cls = 0; pre = 0; up = 0; bi = 0; wb = 0; ld = 0; rsel = 0;
    kind = 0; base = 0; roff = 0; imm12 = 0; ihi = 0; ilo = 0; wdat = 0; rdat = 0;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10 reset vld", {31'h0, vld}, 32'h0);
    chk("R10 reset wb_en", {31'h0, wb_en}, 32'h0);
    chk("R10 reset be", {28'h0, be}, 32'h0);
    chk("R10 reset err", {31'h0, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      e = model(VEC[i]);
      @(negedge clk);
      chk($sformatf("R10 vec%0d vld", i), {31'h0, vld}, 32'h1);
      chk($sformatf("R1/R2/R3 vec%0d addr", i), addr, VEC[i].e_addr);
      chk($sformatf("R6/R7 vec%0d be", i), {28'h0, be}, {28'h0, VEC[i].e_be});
      chk($sformatf("R9 vec%0d err", i), {31'h0, err}, {31'h0, VEC[i].e_err});
      chk($sformatf("R1/R2 vec%0d wb_en", i), {31'h0, wb_en}, {31'h0, e.wb_en});
      if (e.wb_en) chk($sformatf("R3 vec%0d wb_val", i), wbv, e.wbv);
      if (!VEC[i].e_err) begin
        chk($sformatf("R4/R5 vec%0d size", i), {30'h0, size}, {30'h0, e.size});
        if (VEC[i].ld) chk($sformatf("R8 vec%0d ldata", i), ldo, e.ldo);
        else           chk($sformatf("R6/R7 vec%0d wdata", i), wdo, e.wdo);
      end
    end

    // R1: post-index writes back even with wb_i=1
    drive('{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b00, 32'h900, 32'h0, 12'h008,
            4'h0,4'h0, 32'h0, 32'h0, 32'h900, 4'hF, 1'b0});
    @(negedge clk);
    chk("R1 post wb ignore wb_en", {31'h0, wb_en}, 32'h1);
    chk("R1 post addr", addr, 32'h900);
    chk("R1 post wb_val", wbv, 32'h908);

    // R8: ldata follows rdata_i in the same cycle (signed byte lane 3)
    drive('{1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,2'b10, 32'hA000, 32'h0, 12'h000,
            4'h0,4'h3, 32'h0, 32'h80000000, 32'hA003, 4'h8, 1'b0});
    @(negedge clk);
    req = 1'b0;
    chk("R8 lane3 signed", ldo, 32'hFFFFFF80);
    rdat = 32'h7F000000;
    #1;
    chk("R8 same-cycle rdata follow", ldo, 32'h0000007F);

    // R10: idle cycle drops strobes, address holds
    @(negedge clk);
    chk("R10 idle vld", {31'h0, vld}, 32'h0);
    chk("R10 idle be", {28'h0, be}, 32'h0);
    chk("R10 idle wb_en", {31'h0, wb_en}, 32'h0);
    chk("R10 idle addr hold", addr, 32'hA003);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule